// File: doc/BRIEF.md
# Debug Port Scan-Chain Target

This block is the target end of a scan-based debug port. It sits behind a TAP controller that has already decoded its state machine into single-cycle strobes: capture, shift and update for the instruction path, and the same three for the data path. The block takes those strobes and TDI, and it drives TDO. A 4-bit instruction register chooses the data chain that is scanned. The choices are a 32-bit identification chain, a 35-bit access chain used for port-register, remote-port and cancel operations, and a 1-bit bypass chain for every other code.

Reads are posted. The capture phase of an access scan loads the result of the previous operation and a 3-bit acknowledge code. The update phase launches the new operation from the shifted value. Operations on the remote port go out through a level request/acknowledge bus. The port select comes from the bank-select register and the register address within the bank comes from the scanned address bits. To get remote read data, the host scans a read of the result buffer. That read returns the held result and starts no new access. A busy remote port makes the scan answer WAIT. A remote error is sticky: the scan answers FAULT and blocks further remote accesses until the host clears it through the cancel chain.

Top module: `dpt_scan_target`

## Requirements
- R1: The instruction register is 4 bits wide and resets to 4'b1110. An instruction capture loads 4'b0001. The code 4'b1110 selects the identification chain, 4'b1000 the cancel chain, 4'b1010 port-register access and 4'b1011 remote-port access. Any other code selects a 1-bit bypass chain that captures 0.
- R2: The identification chain is 32 bits long and captures the ID_VALUE parameter. An update of this chain changes nothing.
- R3: All three access chains are 35 bits long, with bit 0 = read-not-write, bits 2:1 = address bits [3:2] and bits 34:3 = data. A data capture loads the result buffer into bits 34:3 and the acknowledge into bits 2:0, where OK = 3'b010, WAIT = 3'b001 and FAULT = 3'b100.
- R4: A port-register read places its value in the result buffer, and that value is returned by the next access scan. A read of address 0x4 returns the control/status word, 0x8 returns bank select and 0x0 returns zero. A read of 0xC leaves the buffer unchanged and starts no remote access.
- R5: A write to the control/status register at 0x4 stores only the bits set in CTL_WMASK. Bit 5 of its read value is the sticky error flag, which a write cannot set.
- R6: Bank select (0x8) resets to 0. It keeps bits 31:24 (port select) and bits 7:4 (bank), and every other bit reads 0.
- R7: A port-register write to 0x0 or 0xC has no effect.
- R8: A remote update drives ap_req with ap_sel = bank-select bits 31:24, ap_addr = {bank, address bits [3:2]}, ap_write = not read-not-write and ap_wdata = the data field. These hold stable until ap_ack.
- R9: When ap_ack arrives for a remote read, the result buffer takes ap_rdata. The scan that launched the read captures the earlier result.
- R10: A port-register or remote update that arrives while a request is outstanding is dropped. Exactly the next access-chain capture reports WAIT.
- R11: ap_err on an acknowledge sets the sticky error flag. While the flag is set, access captures report FAULT and remote updates launch nothing.
- R12: A cancel-chain update ignores read-not-write and the address bits. Data bit 0 withdraws an outstanding request, and data bit 1 clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_capture | input | 1 | Instruction capture strobe |
| ir_shift | input | 1 | Instruction shift enable |
| ir_update | input | 1 | Instruction update strobe |
| dr_capture | input | 1 | Data capture strobe |
| dr_shift | input | 1 | Data shift enable |
| dr_update | input | 1 | Data update strobe |
| tdi | input | 1 | Serial input, LSB first |
| tdo | output | 1 | Serial output of the chain scanned most recently |
| ap_req | output | 1 | Remote request, held until acknowledged |
| ap_write | output | 1 | Remote request is a write |
| ap_sel | output | PSEL_W | Remote port select |
| ap_addr | output | BANK_W+2 | Bank and register index |
| ap_wdata | output | DATA_W | Remote write data |
| ap_ack | input | 1 | Remote completion pulse |
| ap_rdata | input | DATA_W | Remote read data, valid with ap_ack |
| ap_err | input | 1 | Remote error, valid with ap_ack |

## Verification
The assertions check several rules on every cycle: request fields stay stable while waiting for an acknowledge, a request never rises while the error flag is set, a dropped update leaves the request untouched, the WAIT marker is consumed by one capture, and the error flag stays set until a cancel. They also check the reset value of the instruction register and the zero captured by the bypass chain. Other behaviour shows only in the bench's scan sequences. These include the posted return of read data one scan later, the field layout of bank select and control/status, the writes that are ignored, and recovery from WAIT, FAULT and a withdrawn request.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

   localparam int INS_W = 4;

   localparam logic [INS_W-1:0] INS_IDENT   = 4'b1110;
   localparam logic [INS_W-1:0] INS_CANCEL  = 4'b1000;
   localparam logic [INS_W-1:0] INS_PORTREG = 4'b1010;
   localparam logic [INS_W-1:0] INS_REMOTE  = 4'b1011;
   localparam logic [INS_W-1:0] INS_CAPTURE = 4'b0001;

   localparam logic [2:0] ACK_OK    = 3'b010;
   localparam logic [2:0] ACK_WAIT  = 3'b001;
   localparam logic [2:0] ACK_FAULT = 3'b100;

   localparam int ERR_BIT = 5;

   typedef enum logic [1:0] {
      CH_BYP = 2'd0,
      CH_ID  = 2'd1,
      CH_ACC = 2'd2
   } chain_e;

   typedef enum logic [1:0] {
      RA_ZERO = 2'd0,
      RA_CTL  = 2'd1,
      RA_BANK = 2'd2,
      RA_RES  = 2'd3
   } regaddr_e;

   function automatic chain_e chain_of(input logic [INS_W-1:0] ins);
      chain_e c;
      case (ins)
         INS_IDENT:                          c = CH_ID;
         INS_CANCEL, INS_PORTREG, INS_REMOTE: c = CH_ACC;
         default:                            c = CH_BYP;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/dpt_ir.sv
module dpt_ir
   import dpt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic             shift,
   input  logic             upd,
   input  logic             tdi,
   output logic [INS_W-1:0] ir_q,
   output logic             tdo_ir
);

   logic [INS_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
         ir_q <= INS_IDENT;
      end else begin
         if (cap)
            sh_q <= INS_CAPTURE;
         else if (shift)
            sh_q <= {tdi, sh_q[INS_W-1:1]};
         if (upd)
            ir_q <= sh_q;
      end
   end

   assign tdo_ir = sh_q[0];

   AST_IR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ir_q == INS_IDENT); // R1
   AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> tdo_ir == 1'b1); // R1

endmodule

// File: rtl/dpt_chain.sv
module dpt_chain
   import dpt_pkg::*;
#(
   parameter int               DATA_W   = 32,
   parameter logic [31:0]      ID_VALUE = 32'h2D05_A0C7,
   localparam int              ACC_W    = DATA_W + 3,
   localparam int              IDX_W    = $clog2(ACC_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic             shift,
   input  chain_e           sel,
   input  logic             tdi,
   input  logic [ACC_W-1:0] acc_cap,
   output logic [ACC_W-1:0] sh_q,
   output logic             tdo_dr
);

   logic [IDX_W-1:0] top_idx;
   logic [ACC_W-1:0] nxt;

   always_comb begin
      case (sel)
         CH_ID:   top_idx = IDX_W'(31);
         CH_ACC:  top_idx = IDX_W'(ACC_W - 1);
         default: top_idx = '0;
      endcase
   end

   for (genvar i = 0; i < ACC_W; i++) begin : g_bit
      if (i == ACC_W - 1) begin : g_top
         assign nxt[i] = tdi;
      end else begin : g_mid
         assign nxt[i] = (top_idx == IDX_W'(i)) ? tdi : sh_q[i+1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (cap) begin
         case (sel)
            CH_ID:   sh_q <= ACC_W'(ID_VALUE);
            CH_ACC:  sh_q <= acc_cap;
            default: sh_q <= '0;
         endcase
      end else if (shift) begin
         sh_q <= nxt;
      end
   end

   assign tdo_dr = sh_q[0];

   AST_BYPASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cap && sel == CH_BYP |=> tdo_dr == 1'b0); // R1

endmodule

// File: rtl/dpt_regs.sv
module dpt_regs
   import dpt_pkg::*;
#(
   parameter int              DATA_W    = 32,
   parameter int              PSEL_W    = 8,
   parameter int              BANK_W    = 4,
   parameter logic [31:0]     CTL_WMASK = 32'hF000_FF0F,
   localparam int             ACC_W     = DATA_W + 3,
   localparam int             ADDR_W    = BANK_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dr_cap,
   input  logic              dr_upd,
   input  logic [INS_W-1:0]  ir_q,
   input  logic [ACC_W-1:0]  sh_q,
   output logic [ACC_W-1:0]  cap_word,
   output logic              ap_req,
   output logic              ap_write,
   output logic [PSEL_W-1:0] ap_sel,
   output logic [ADDR_W-1:0] ap_addr,
   output logic [DATA_W-1:0] ap_wdata,
   input  logic              ap_ack,
   input  logic [DATA_W-1:0] ap_rdata,
   input  logic              ap_err
);

   localparam logic [DATA_W-1:0] WMASK = DATA_W'(CTL_WMASK);

   logic              rnw;
   regaddr_e          ra;
   logic [DATA_W-1:0] dfield;
   logic              port_fire, rem_fire, can_fire, acc_cap, rem_go;

   logic [DATA_W-1:0] ctl_q, result_q;
   logic [PSEL_W-1:0] psel_q;
   logic [BANK_W-1:0] bank_q;
   logic              err_q, wait_q, busy_q;

   logic [DATA_W-1:0] ctl_rd, bank_rd;
   logic [2:0]        ack_code;

   assign rnw    = sh_q[0];
   assign ra     = regaddr_e'(sh_q[2:1]);
   assign dfield = sh_q[ACC_W-1:3];

   assign port_fire = dr_upd && (ir_q == INS_PORTREG);
   assign rem_fire  = dr_upd && (ir_q == INS_REMOTE);
   assign can_fire  = dr_upd && (ir_q == INS_CANCEL);
   assign acc_cap   = dr_cap && (chain_of(ir_q) == CH_ACC);
   assign rem_go    = rem_fire && !busy_q && !err_q;

   always_comb begin
      ctl_rd          = ctl_q & WMASK;
      ctl_rd[ERR_BIT] = err_q;
   end

   always_comb begin
      bank_rd                       = '0;
      bank_rd[DATA_W-1 -: PSEL_W]   = psel_q;
      bank_rd[4 +: BANK_W]          = bank_q;
   end

   always_comb begin
      if (wait_q)
         ack_code = ACK_WAIT;
      else if (err_q)
         ack_code = ACK_FAULT;
      else
         ack_code = ACK_OK;
   end

   assign cap_word = {result_q, ack_code};

   // port-register file and result buffer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         psel_q <= '0;
         bank_q <= '0;
      end else if (port_fire && !busy_q && !rnw) begin
         case (ra)
            RA_CTL:  ctl_q <= dfield & WMASK;
            RA_BANK: begin
               psel_q <= dfield[DATA_W-1 -: PSEL_W];
               bank_q <= dfield[4 +: BANK_W];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
      end else if (busy_q && ap_ack && !ap_write) begin
         result_q <= ap_rdata;
      end else if (port_fire && !busy_q && rnw) begin
         case (ra)
            RA_ZERO: result_q <= '0;
            RA_CTL:  result_q <= ctl_rd;
            RA_BANK: result_q <= bank_rd;
            default: ;
         endcase
      end
   end

   // remote request engine, wait marker and sticky error
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         wait_q   <= 1'b0;
         err_q    <= 1'b0;
         ap_write <= 1'b0;
         ap_sel   <= '0;
         ap_addr  <= '0;
         ap_wdata <= '0;
      end else begin
         if (acc_cap)
            wait_q <= 1'b0;
         if ((port_fire || rem_fire) && busy_q)
            wait_q <= 1'b1;
         if (rem_go) begin
            busy_q   <= 1'b1;
            ap_write <= !rnw;
            ap_sel   <= psel_q;
            ap_addr  <= {bank_q, sh_q[2:1]};
            ap_wdata <= dfield;
         end
         if (busy_q && ap_ack) begin
            busy_q <= 1'b0;
            if (ap_err)
               err_q <= 1'b1;
         end
         if (can_fire) begin
            if (dfield[0])
               busy_q <= 1'b0;
            if (dfield[1])
               err_q <= 1'b0;
         end
      end
   end

   assign ap_req = busy_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ap_req && !ap_ack && !(can_fire && dfield[0])
      |=> ap_req && $stable(ap_addr) && $stable(ap_sel) && $stable(ap_wdata) && $stable(ap_write)); // R8
   AST_NO_LAUNCH_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ap_req) |-> !$past(err_q)); // R11
   AST_DROPPED_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      rem_fire && ap_req && !ap_ack |=> $stable(ap_addr) && $stable(ap_wdata)); // R10
   AST_WAIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q && acc_cap |=> !wait_q); // R10
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q && !can_fire |=> err_q); // R11

endmodule

// File: rtl/dpt_scan_target.sv
module dpt_scan_target
   import dpt_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          PSEL_W    = 8,
   parameter int          BANK_W    = 4,
   parameter logic [31:0] ID_VALUE  = 32'h2D05_A0C7,
   parameter logic [31:0] CTL_WMASK = 32'hF000_FF0F
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ir_capture,
   input  logic                ir_shift,
   input  logic                ir_update,
   input  logic                dr_capture,
   input  logic                dr_shift,
   input  logic                dr_update,
   input  logic                tdi,
   output logic                tdo,
   output logic                ap_req,
   output logic                ap_write,
   output logic [PSEL_W-1:0]   ap_sel,
   output logic [BANK_W+1:0]   ap_addr,
   output logic [DATA_W-1:0]   ap_wdata,
   input  logic                ap_ack,
   input  logic [DATA_W-1:0]   ap_rdata,
   input  logic                ap_err
);

   localparam int ACC_W = DATA_W + 3;

   if (DATA_W != 32) begin : g_bad_width
      $error("dpt_scan_target: DATA_W must be 32");
   end
   if (PSEL_W + BANK_W + 4 > DATA_W) begin : g_bad_fields
      $error("dpt_scan_target: bank-select fields overlap");
   end
   if (CTL_WMASK[ERR_BIT]) begin : g_bad_mask
      $error("dpt_scan_target: CTL_WMASK must leave the error bit clear");
   end

   logic [INS_W-1:0] ir_q;
   logic             tdo_ir, tdo_dr, ir_path_q;
   logic [ACC_W-1:0] sh_q, cap_word;
   chain_e           sel;

   assign sel = chain_of(ir_q);

   dpt_ir u_ir (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap    (ir_capture),
      .shift  (ir_shift),
      .upd    (ir_update),
      .tdi    (tdi),
      .ir_q   (ir_q),
      .tdo_ir (tdo_ir)
   );

   dpt_chain #(
      .DATA_W   (DATA_W),
      .ID_VALUE (ID_VALUE)
   ) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (dr_capture),
      .shift   (dr_shift),
      .sel     (sel),
      .tdi     (tdi),
      .acc_cap (cap_word),
      .sh_q    (sh_q),
      .tdo_dr  (tdo_dr)
   );

   dpt_regs #(
      .DATA_W    (DATA_W),
      .PSEL_W    (PSEL_W),
      .BANK_W    (BANK_W),
      .CTL_WMASK (CTL_WMASK)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .dr_cap   (dr_capture),
      .dr_upd   (dr_update),
      .ir_q     (ir_q),
      .sh_q     (sh_q),
      .cap_word (cap_word),
      .ap_req   (ap_req),
      .ap_write (ap_write),
      .ap_sel   (ap_sel),
      .ap_addr  (ap_addr),
      .ap_wdata (ap_wdata),
      .ap_ack   (ap_ack),
      .ap_rdata (ap_rdata),
      .ap_err   (ap_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ir_path_q <= 1'b0;
      else if (ir_capture)
         ir_path_q <= 1'b1;
      else if (dr_capture)
         ir_path_q <= 1'b0;
   end

   assign tdo = ir_path_q ? tdo_ir : tdo_dr;

endmodule

// File: tb/dpt_scan_target_tb.sv
`timescale 1ns/1ps
module dpt_scan_target_tb;

   localparam logic [31:0] TB_ID   = 32'h2D05_A0C7;
   localparam logic [31:0] TB_MASK = 32'hF000_FF0F;
   localparam logic [3:0]  I_ID  = 4'b1110, I_CAN = 4'b1000, I_PRT = 4'b1010, I_REM = 4'b1011;
   localparam logic [2:0]  OK = 3'b010, WT = 3'b001, FT = 3'b100;

   logic        clk = 0, rst_n = 0;
   logic        ir_capture = 0, ir_shift = 0, ir_update = 0;
   logic        dr_capture = 0, dr_shift = 0, dr_update = 0, tdi = 0;
   logic        tdo, ap_req, ap_write, ap_ack, ap_err;
   logic [7:0]  ap_sel;
   logic [5:0]  ap_addr;
   logic [31:0] ap_wdata, ap_rdata;

   int checks = 0, errors = 0;
   int stub_delay = 2, cnt = 0, req_count = 0;
   logic req_d = 0;
   logic [7:0]  last_sel;
   logic [5:0]  last_addr;
   logic        last_write;
   logic [31:0] last_wdata;
   logic [3:0]  cur_ir;

   always #2.5 clk = ~clk;

   dpt_scan_target #(.ID_VALUE(TB_ID), .CTL_WMASK(TB_MASK)) u_dut (
      .clk(clk), .rst_n(rst_n), .ir_capture(ir_capture), .ir_shift(ir_shift),
      .ir_update(ir_update), .dr_capture(dr_capture), .dr_shift(dr_shift),
      .dr_update(dr_update), .tdi(tdi), .tdo(tdo), .ap_req(ap_req),
      .ap_write(ap_write), .ap_sel(ap_sel), .ap_addr(ap_addr), .ap_wdata(ap_wdata),
      .ap_ack(ap_ack), .ap_rdata(ap_rdata), .ap_err(ap_err));

   function automatic logic [31:0] stub_data(input logic [7:0] s, input logic [5:0] a);
      return 32'hD000_0000 | {16'h0, s, 2'b00, a};
   endfunction

   // remote-port stub: acknowledges after stub_delay cycles, errors on register index 3
   always @(posedge clk) begin
      req_d <= ap_req;
      if (ap_req && !req_d) begin
         req_count  <= req_count + 1;
         last_sel   <= ap_sel;
         last_addr  <= ap_addr;
         last_write <= ap_write;
         last_wdata <= ap_wdata;
      end
      if (!rst_n) begin
         ap_ack <= 0; ap_err <= 0; ap_rdata <= 0; cnt <= 0;
      end else if (ap_ack) begin
         ap_ack <= 0; cnt <= 0;
      end else if (ap_req) begin
         if (cnt >= stub_delay) begin
            ap_ack   <= 1;
            ap_rdata <= stub_data(ap_sel, ap_addr);
            ap_err   <= (ap_addr[1:0] == 2'b11);
         end else cnt <= cnt + 1;
      end else cnt <= 0;
   end

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
      @(negedge clk) ir_capture = 1;
      @(negedge clk) ir_capture = 0; ir_shift = 1;
      for (int i = 0; i < 4; i++) begin
         cap[i] = tdo; tdi = code[i];
         @(negedge clk);
      end
      ir_shift = 0; ir_update = 1;
      @(negedge clk) ir_update = 0;
      cur_ir = code;
   endtask

   task automatic set_ir(input logic [3:0] code);
      logic [3:0] c;
      if (cur_ir != code) scan_ir(code, c);
   endtask

   task automatic scan_dr(input int n, input logic [34:0] din, output logic [34:0] dout);
      dout = '0;
      @(negedge clk) dr_capture = 1;
      @(negedge clk) dr_capture = 0; dr_shift = 1;
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo; tdi = din[i];
         @(negedge clk);
      end
      dr_shift = 0; dr_update = 1;
      @(negedge clk) dr_update = 0;
   endtask

   task automatic acc(input logic rnw, input logic [1:0] a, input logic [31:0] d,
                      output logic [31:0] cd, output logic [2:0] ck);
      logic [34:0] o;
      scan_dr(35, {d, a, rnw}, o);
      cd = o[34:3]; ck = o[2:0];
   endtask

   task automatic t_reset;
      logic [34:0] o;
      check(ap_req == 0, "R8 reset request low", ap_req, 0);
      scan_dr(32, 35'h0, o);
      check(o[31:0] == TB_ID, "R1 reset instruction selects ident", o[31:0], TB_ID);
   endtask

   task automatic t_ir_and_bypass;
      logic [3:0] c; logic [34:0] o; logic [7:0] pat = 8'b1011_0110;
      scan_ir(4'b0000, c);
      check(c == 4'b0001, "R1 instruction capture pattern", c, 4'b0001);
      scan_dr(8, {27'h0, pat}, o);
      check(o[7:0] == {pat[6:0], 1'b0}, "R1 bypass one bit captures 0", o[7:0], {pat[6:0], 1'b0});
   endtask

   task automatic t_ident;
      logic [34:0] o;
      set_ir(I_ID);
      scan_dr(32, 35'h0, o);
      scan_dr(32, 35'h0, o);
      check(o[31:0] == TB_ID, "R2 ident unchanged after update", o[31:0], TB_ID);
   endtask

   task automatic t_bank;
      logic [31:0] d; logic [2:0] k;
      set_ir(I_PRT);
      acc(1, 2'd2, 0, d, k);
      acc(1, 2'd3, 0, d, k);
      check(d == 0, "R6 bank select resets to 0", d, 0);
      check(k == OK, "R3 ack OK code", k, OK);
      acc(0, 2'd2, 32'hFFFF_FFFF, d, k);
      acc(1, 2'd2, 0, d, k);
      acc(1, 2'd3, 0, d, k);
      check(d == 32'hFF00_00F0, "R6 bank select fields", d, 32'hFF00_00F0);
   endtask

   task automatic t_ctl;
      logic [31:0] d; logic [2:0] k;
      set_ir(I_PRT);
      acc(0, 2'd1, 32'hFFFF_FFFF, d, k);
      acc(1, 2'd1, 0, d, k);
      acc(0, 2'd0, 32'h1234_5678, d, k);
      check(d == 32'hF000_FF0F, "R5 control masked write, posted read R4", d, 32'hF000_FF0F);
      acc(0, 2'd3, 32'hABCD_0000, d, k);
      acc(1, 2'd3, 0, d, k);
      check(d == 32'hF000_FF0F, "R7 writes to 0x0 and 0xC ignored", d, 32'hF000_FF0F);
      acc(1, 2'd0, 0, d, k);
      acc(1, 2'd3, 0, d, k);
      check(d == 0, "R4 read of 0x0 returns zero", d, 0);
   endtask

   task automatic t_remote_write;
      logic [31:0] d; logic [2:0] k; int n0;
      set_ir(I_PRT);
      acc(0, 2'd2, 32'h0300_0020, d, k);
      n0 = req_count;
      set_ir(I_REM);
      acc(0, 2'd1, 32'hCAFE_F00D, d, k);
      repeat (10) @(negedge clk);
      check(req_count == n0 + 1, "R8 one request launched", req_count, n0 + 1);
      check(last_sel == 8'h03, "R8 port select", last_sel, 8'h03);
      check(last_addr == 6'h09, "R8 bank and index", last_addr, 6'h09);
      check(last_write && last_wdata == 32'hCAFE_F00D, "R8 write data", last_wdata, 32'hCAFE_F00D);
   endtask

   task automatic t_remote_read;
      logic [31:0] d; logic [2:0] k; int n0;
      set_ir(I_REM);
      acc(1, 2'd2, 0, d, k);
      check(d == 0, "R9 launching scan returns earlier result", d, 0);
      repeat (10) @(negedge clk);
      n0 = req_count;
      set_ir(I_PRT);
      acc(1, 2'd3, 0, d, k);
      check(d == stub_data(8'h03, 6'h0A), "R9 result buffer holds remote data", d, stub_data(8'h03, 6'h0A));
      acc(1, 2'd3, 0, d, k);
      check(d == stub_data(8'h03, 6'h0A), "R4 buffer read repeats result", d, stub_data(8'h03, 6'h0A));
      check(req_count == n0, "R4 buffer read starts no access", req_count, n0);
   endtask

   task automatic t_wait;
      logic [31:0] d; logic [2:0] k; int n0;
      stub_delay = 100000;
      n0 = req_count;
      set_ir(I_REM);
      acc(1, 2'd0, 0, d, k);
      acc(0, 2'd1, 32'h1111_2222, d, k);
      check(ap_req == 1, "R10 request still outstanding", ap_req, 1);
      stub_delay = 0;
      repeat (10) @(negedge clk);
      check(req_count == n0 + 1 && last_write == 0, "R10 dropped update not launched", req_count, n0 + 1);
      set_ir(I_PRT);
      acc(1, 2'd3, 0, d, k);
      check(k == WT, "R10 WAIT after dropped update", k, WT);
      check(d == stub_data(8'h03, 6'h08), "R9 completed read in buffer", d, stub_data(8'h03, 6'h08));
      acc(1, 2'd3, 0, d, k);
      check(k == OK, "R10 WAIT reported once", k, OK);
      stub_delay = 2;
   endtask

   task automatic t_fault;
      logic [31:0] d; logic [2:0] k; int n0;
      set_ir(I_REM);
      acc(1, 2'd3, 0, d, k);
      repeat (10) @(negedge clk);
      set_ir(I_PRT);
      acc(1, 2'd1, 0, d, k);
      check(k == FT, "R11 FAULT after remote error", k, FT);
      acc(1, 2'd3, 0, d, k);
      check(d == 32'hF000_FF2F, "R5 error flag at bit 5", d, 32'hF000_FF2F);
      n0 = req_count;
      set_ir(I_REM);
      acc(0, 2'd0, 32'h5, d, k);
      repeat (10) @(negedge clk);
      check(req_count == n0, "R11 no launch while error set", req_count, n0);
      set_ir(I_CAN);
      acc(1, 2'd3, 32'h2, d, k);
      set_ir(I_PRT);
      acc(1, 2'd3, 0, d, k);
      check(k == OK, "R12 cancel bit 1 clears error", k, OK);
   endtask

   task automatic t_abandon;
      logic [31:0] d; logic [2:0] k;
      stub_delay = 100000;
      set_ir(I_REM);
      acc(0, 2'd2, 32'h77, d, k);
      check(ap_req == 1, "R8 request held without ack", ap_req, 1);
      set_ir(I_CAN);
      acc(0, 2'd0, 32'h1, d, k);
      @(negedge clk);
      check(ap_req == 0, "R12 cancel bit 0 withdraws request", ap_req, 0);
      stub_delay = 2;
      set_ir(I_REM);
      acc(1, 2'd1, 0, d, k);
      repeat (10) @(negedge clk);
      set_ir(I_PRT);
      acc(1, 2'd3, 0, d, k);
      check(k == OK && d == stub_data(8'h03, 6'h09), "R12 new access after withdraw", d, stub_data(8'h03, 6'h09));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      cur_ir = I_ID;
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_ir_and_bypass();
      t_ident();
      t_bank();
      t_ctl();
      t_remote_write();
      t_remote_read();
      t_wait();
      t_fault();
      t_abandon();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule